// File: doc/BRIEF.md
# Burst-Limited FIFO Chunking Engine

This engine moves a byte stream of any length between an upstream client and a peripheral's data FIFO register. It relies on a lower block that runs single register transactions on the serial bus. Before every chunk it reads the peripheral's 32-bit status register through that lower block and takes out the current burst allowance. A zero allowance means the peripheral is busy, and the engine asks again. Otherwise it issues one FIFO transaction whose length is the smallest of three values: the bytes still owed, the allowance, and the 64-byte frame cap.

A client starts a transfer with a one-cycle `start` pulse, which carries a direction and a length. In receive mode, FIFO bytes from the lower block are passed upward. In transmit mode, byte pulls from the lower block are passed upward and the client's data is passed down. Status bytes never reach the client. The transfer ends with a one-cycle `done` pulse, together with an error code and the count of bytes actually moved.

The lower-block handshake works as follows. `lo_req` is held high, with stable address, length and direction, until a one-cycle `lo_done` arrives. `lo_err` is valid only in that cycle. If `lo_req` is still high in the cycle after `lo_done`, a new transaction begins. Read data arrives as `lo_rx_valid` byte strobes, and `lo_done` comes no earlier than the cycle after the last byte.

Top module: `burst_chunk_engine`

## Requirements
- R1: After reset, `lo_req`, `busy`, `done` and `err_code` are all low, and `up_rx_valid` and `up_tx_pull` stay low.
- R2: Every chunk is preceded by a read transaction (`lo_rd`=1) of length 4 at address `STS_ADDR` (default 0x18). Request fields stay stable while `lo_req` waits for `lo_done`.
- R3: The burst allowance is status bits 23:8. Status arrives least significant byte first, so the allowance is received byte 1 (low) and received byte 2 (high). Bytes 0 and 3 have no effect.
- R4: A status read with an allowance of zero is followed directly by another status read, with no FIFO transaction in between.
- R5: Each FIFO transaction length equals min(bytes remaining, allowance, `MAX_CHUNK`=64), and is never zero.
- R6: FIFO transactions use address `FIFO_ADDR` (default 0x24). `lo_rd` equals the latched `dir`: 1 means receive (read), 0 means transmit (write).
- R7: Chunks repeat until the bytes moved equal `xfer_len`. Then `done` pulses for exactly one cycle with `err_code`=0 and `moved`=`xfer_len`.
- R8: A `lo_err` in any transaction ends the transfer with `err_code`=1, and no further request is issued.
- R9: A `xfer_len` of 0 gives `done` with `err_code`=0 in the cycle after `start` and issues no request.
- R10: When `POLL_LIMIT` (non-zero) consecutive status reads return a zero allowance, the transfer ends with `err_code`=2. The count restarts after each chunk.
- R11: Receive bytes reach `up_rx_valid`/`up_rx_data` only during FIFO reads, in arrival order. `up_tx_pull` follows `lo_tx_pull` only during FIFO writes, and `lo_tx_data` carries `up_tx_data`.
- R12: A `start` pulse while `busy` is high is ignored and does not alter the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle transfer request |
| dir | input | 1 | 1 = receive from FIFO, 0 = transmit to FIFO |
| xfer_len | input | LEN_W | Total bytes to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 lower-block error, 2 busy timeout |
| moved | output | LEN_W | Bytes completed in this transfer |
| up_rx_valid | output | 1 | Received FIFO byte strobe to client |
| up_rx_data | output | 8 | Received FIFO byte |
| up_tx_pull | output | 1 | Client must supply the next transmit byte |
| up_tx_data | input | 8 | Transmit byte from client |
| lo_req | output | 1 | Transaction request to lower block |
| lo_rd | output | 1 | Transaction is a read |
| lo_addr | output | ADDR_W | Register address |
| lo_len | output | CHUNK_W | Transaction length in bytes (1..64) |
| lo_rx_valid | input | 1 | Read byte strobe from lower block |
| lo_rx_data | input | 8 | Read byte from lower block |
| lo_tx_pull | input | 1 | Lower block consumes a write byte |
| lo_tx_data | output | 8 | Write byte to lower block |
| lo_done | input | 1 | Transaction finished |
| lo_err | input | 1 | Transaction failed, valid with `lo_done` |

## Verification
Allowance sequences are picked so that each limit of the three-way minimum wins at least once. The 64-byte cap wins with a huge allowance, the allowance wins with a small repeating value, and the remainder wins on the final short chunk. A length of exactly 64 probes the boundary where cap and remainder coincide. One allowance is non-zero only in its upper byte, with non-zero filler in status bytes 0 and 3, so a wrong byte order or field position shows up as a wrong chunk length. Zero-allowance prefixes show re-polling, and an all-zero sequence shows the timeout. Error injection on a status read, and separately on a FIFO transaction, shows the abort path.

// File: rtl/burst_chunk_engine.sv
module burst_chunk_engine #(
  parameter int LEN_W = 16,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] STS_ADDR = 24'h000018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 24'h000024,
  parameter int MAX_CHUNK = 64,
  parameter int POLL_LIMIT = 1000,
  localparam int CHUNK_W = $clog2(MAX_CHUNK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [LEN_W-1:0]  moved,
  output logic              up_rx_valid,
  output logic [7:0]        up_rx_data,
  output logic              up_tx_pull,
  input  logic [7:0]        up_tx_data,
  output logic              lo_req,
  output logic              lo_rd,
  output logic [ADDR_W-1:0] lo_addr,
  output logic [CHUNK_W-1:0] lo_len,
  input  logic              lo_rx_valid,
  input  logic [7:0]        lo_rx_data,
  input  logic              lo_tx_pull,
  output logic [7:0]        lo_tx_data,
  input  logic              lo_done,
  input  logic              lo_err
);

  localparam int MW = (LEN_W > 16) ? LEN_W : 16;
  localparam int POLL_W = $clog2(POLL_LIMIT + 2);

  typedef enum logic [1:0] {S_IDLE, S_STS, S_FIFO, S_FIN} state_t;

  state_t             st;
  logic               dir_q;
  logic [LEN_W-1:0]   remain;
  logic [CHUNK_W-1:0] chunk;
  logic [15:0]        burst_q;
  logic [1:0]         byte_idx;
  logic [POLL_W-1:0]  polls;
  logic [1:0]         err_q;

  logic [MW-1:0] rem_x, bur_x, cap_x, min_rb, min_all;
  logic [CHUNK_W-1:0] next_chunk;
  logic poll_expired;

  assign rem_x   = MW'(remain);
  assign bur_x   = MW'(burst_q);
  assign cap_x   = MW'(MAX_CHUNK);
  assign min_rb  = (rem_x < bur_x) ? rem_x : bur_x;
  assign min_all = (min_rb < cap_x) ? min_rb : cap_x;
  assign next_chunk = CHUNK_W'(min_all);

  assign poll_expired = (POLL_LIMIT != 0) &&
                        ((polls + POLL_W'(1)) == POLL_W'(POLL_LIMIT));

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign err_code = err_q;

  assign lo_req  = (st == S_STS) || (st == S_FIFO);
  assign lo_rd   = (st == S_STS) ? 1'b1 : dir_q;
  assign lo_addr = (st == S_STS) ? STS_ADDR : FIFO_ADDR;
  assign lo_len  = (st == S_STS) ? CHUNK_W'(4) : chunk;

  assign up_rx_valid = lo_rx_valid && (st == S_FIFO) && dir_q;
  assign up_rx_data  = lo_rx_data;
  assign up_tx_pull  = lo_tx_pull && (st == S_FIFO) && !dir_q;
  assign lo_tx_data  = up_tx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx <= '0;
      burst_q  <= '0;
    end else if (start && st == S_IDLE) begin
      byte_idx <= '0;
    end else if (st == S_STS) begin
      if (lo_done) begin
        byte_idx <= '0;
      end else if (lo_rx_valid) begin
        byte_idx <= byte_idx + 2'd1;
        if (byte_idx == 2'd1) burst_q[7:0]  <= lo_rx_data;
        if (byte_idx == 2'd2) burst_q[15:8] <= lo_rx_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_q  <= 1'b0;
      remain <= '0;
      moved  <= '0;
      chunk  <= '0;
      polls  <= '0;
      err_q  <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dir_q  <= dir;
          remain <= xfer_len;
          moved  <= '0;
          polls  <= '0;
          err_q  <= 2'd0;
          st     <= (xfer_len == '0) ? S_FIN : S_STS;
        end
        S_STS: if (lo_done) begin
          if (lo_err) begin
            err_q <= 2'd1;
            st    <= S_FIN;
          end else if (burst_q == 16'd0) begin
            polls <= polls + POLL_W'(1);
            if (poll_expired) begin
              err_q <= 2'd2;
              st    <= S_FIN;
            end
          end else begin
            chunk <= next_chunk;
            st    <= S_FIFO;
          end
        end
        S_FIFO: if (lo_done) begin
          if (lo_err) begin
            err_q <= 2'd1;
            st    <= S_FIN;
          end else begin
            moved  <= moved + LEN_W'(chunk);
            remain <= remain - LEN_W'(chunk);
            polls  <= '0;
            st     <= (remain == LEN_W'(chunk)) ? S_FIN : S_STS;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CHUNK_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIFO) |-> (lo_len != '0) && (lo_len <= CHUNK_W'(MAX_CHUNK)) &&
                       (LEN_W'(lo_len) <= remain) && (16'(lo_len) <= burst_q)); // R5
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_req && !lo_done) |=> lo_req && $stable(lo_addr) && $stable(lo_len) && $stable(lo_rd)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && xfer_len == '0) |=> done && (err_code == 2'd0)); // R9
  AST_NO_STS_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_req && lo_addr == STS_ADDR) |-> !up_rx_valid && !up_tx_pull); // R11
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_req && lo_done && lo_err) |=> done && (err_code == 2'd1) && !lo_req); // R8

endmodule

// File: tb/test_burst_chunk_engine.sv
module test_burst_chunk_engine;
  localparam int CLK_PERIOD = 10;
  localparam int POLLS = 4;
  localparam int NV = 6;
  localparam logic [23:0] STS_A = 24'h000018;
  localparam logic [23:0] FIFO_A = 24'h000024;

  localparam int V_DIR [NV] = '{1, 0, 1, 0, 1, 1};
  localparam int V_LEN [NV] = '{10, 150, 20, 5, 64, 70};
  localparam int V_B0  [NV] = '{100, 4096, 7, 0, 64, 256};
  localparam int V_B1  [NV] = '{100, 4096, 7, 0, 64, 256};
  localparam int V_B2  [NV] = '{100, 4096, 7, 3, 64, 256};
  localparam int V_B3  [NV] = '{100, 4096, 7, 3, 64, 256};
  localparam int V_STS [NV] = '{1, 3, 3, 4, 1, 2};
  localparam int V_FIFO[NV] = '{1, 3, 3, 2, 1, 2};

  logic clk = 0, rst_n = 0, start = 0, dir = 0;
  logic [15:0] xfer_len = 0;
  logic busy, done, up_rx_valid, up_tx_pull, lo_req, lo_rd;
  logic [1:0] err_code;
  logic [15:0] moved;
  logic [7:0] up_rx_data, lo_tx_data;
  logic [7:0] up_tx_data = 0, lo_rx_data = 0;
  logic [23:0] lo_addr;
  logic [6:0] lo_len;
  logic lo_rx_valid = 0, lo_tx_pull = 0, lo_done = 0, lo_err = 0;

  int n_chk = 0, n_bad = 0;
  logic [15:0] bseq [4];
  int sts_cnt, fifo_cnt, txn_cnt, err_at, rem_m, dir_m, last_burst;
  int up_rx_cnt, rx_bad, tx_bad;
  logic [7:0] rx_src = 8'h10, tx_src = 8'h80, exp_rx;

  burst_chunk_engine #(.POLL_LIMIT(POLLS)) i_burst_chunk_engine (
    .clk, .rst_n, .start, .dir, .xfer_len, .busy, .done, .err_code, .moved,
    .up_rx_valid, .up_rx_data, .up_tx_pull, .up_tx_data,
    .lo_req, .lo_rd, .lo_addr, .lo_len, .lo_rx_valid, .lo_rx_data,
    .lo_tx_pull, .lo_tx_data, .lo_done, .lo_err);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(posedge clk) if (up_rx_valid) begin
    if (up_rx_data !== exp_rx) rx_bad++;
    exp_rx <= exp_rx + 8'd1;
    up_rx_cnt++;
  end

  task automatic serve();
    automatic int n = int'(lo_len);
    automatic logic [31:0] sv;
    automatic int e;
    txn_cnt++;
    if (lo_addr == STS_A) begin
      chk(lo_rd == 1'b1 && n == 4, "R2", n, 4);
      last_burst = bseq[(sts_cnt > 3) ? 3 : sts_cnt];
      sts_cnt++;
      sv = {8'h5A, last_burst[15:0], 8'hA5};
      for (int k = 0; k < 4; k++) begin
        lo_rx_valid = 1; lo_rx_data = sv[8*k +: 8];
        @(negedge clk);
      end
    end else begin
      fifo_cnt++;
      chk(lo_addr == FIFO_A, "R6", lo_addr, FIFO_A);
      chk(lo_rd == dir_m[0], "R6", lo_rd, dir_m);
      e = rem_m;
      if (last_burst < e) e = last_burst;
      if (64 < e) e = 64;
      chk(n == e, "R5", n, e);
      rem_m -= n;
      for (int k = 0; k < n; k++) begin
        if (dir_m != 0) begin
          lo_rx_valid = 1; lo_rx_data = rx_src; rx_src++;
        end else begin
          lo_tx_pull = 1; up_tx_data = tx_src;
          #1;
          if (!(up_tx_pull === 1'b1 && lo_tx_data === tx_src)) tx_bad++;
          tx_src++;
        end
        @(negedge clk);
      end
    end
    lo_rx_valid = 0; lo_tx_pull = 0;
    lo_done = 1; lo_err = (txn_cnt == err_at);
  endtask

  initial begin : lower_model
    forever begin
      @(negedge clk);
      lo_done = 0; lo_err = 0; lo_rx_valid = 0; lo_tx_pull = 0;
      if (rst_n && lo_req) serve();
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic run(input int d, input int len, input int b0, input int b1,
                     input int b2, input int b3, input int ea, input int poke_at);
    automatic int cyc = 0;
    bseq[0] = b0[15:0]; bseq[1] = b1[15:0]; bseq[2] = b2[15:0]; bseq[3] = b3[15:0];
    sts_cnt = 0; fifo_cnt = 0; txn_cnt = 0; err_at = ea; rem_m = len; dir_m = d;
    up_rx_cnt = 0; rx_bad = 0; tx_bad = 0; exp_rx = rx_src; last_burst = 0;
    @(negedge clk);
    start = 1; dir = d[0]; xfer_len = len[15:0];
    @(negedge clk);
    start = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_at) begin start = 1; dir = 0; xfer_len = 16'd3; end
      else start = 0;
    end
    start = 0;
    chk(cyc < 5000, "R7", cyc, 5000);
  endtask

  initial begin : main
    repeat (4) @(negedge clk);
    chk(lo_req === 0 && busy === 0 && done === 0 && err_code === 0, "R1", lo_req, 0);
    chk(up_rx_valid === 0 && up_tx_pull === 0, "R1", up_rx_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(lo_req === 0 && busy === 0, "R1", busy, 0);

    for (int v = 0; v < NV; v++) begin
      run(V_DIR[v], V_LEN[v], V_B0[v], V_B1[v], V_B2[v], V_B3[v], -1, 0);
      chk(err_code == 0, "R7", err_code, 0);
      chk(moved == V_LEN[v], "R7", moved, V_LEN[v]);
      chk(sts_cnt == V_STS[v], "R4 R3", sts_cnt, V_STS[v]);
      chk(fifo_cnt == V_FIFO[v], "R5", fifo_cnt, V_FIFO[v]);
      chk(up_rx_cnt == (V_DIR[v] ? V_LEN[v] : 0), "R11", up_rx_cnt, V_DIR[v] ? V_LEN[v] : 0);
      chk(rx_bad == 0 && tx_bad == 0, "R11", rx_bad + tx_bad, 0);
      @(negedge clk);
      chk(done === 0, "R7", done, 0);
    end

    // R9: zero length
    run(1, 0, 5, 5, 5, 5, -1, 0);
    chk(txn_cnt == 0 && err_code == 0, "R9", txn_cnt, 0);
    @(negedge clk);

    // R10: allowance stays zero
    run(0, 10, 0, 0, 0, 0, -1, 0);
    chk(err_code == 2, "R10", err_code, 2);
    chk(sts_cnt == POLLS && fifo_cnt == 0, "R10", sts_cnt, POLLS);
    @(negedge clk);

    // R8: error on first FIFO transaction
    run(1, 100, 64, 64, 64, 64, 2, 0);
    chk(err_code == 1 && moved == 0, "R8", err_code, 1);
    repeat (6) @(negedge clk);
    chk(txn_cnt == 2 && lo_req === 0, "R8", txn_cnt, 2);

    // R8: error on a status read
    run(1, 30, 64, 64, 64, 64, 1, 0);
    chk(err_code == 1 && fifo_cnt == 0, "R8", fifo_cnt, 0);
    @(negedge clk);

    // R12: start while busy
    run(1, 20, 7, 7, 7, 7, -1, 10);
    chk(moved == 20 && fifo_cnt == 3 && up_rx_cnt == 20, "R12", moved, 20);
    repeat (4) @(negedge clk);
    chk(busy === 0 && lo_req === 0, "R12", busy, 0);

    summary();
  end
endmodule